// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block supervises a periodic heartbeat that a processor drives onto a single input. It is clocked by its own slow watchdog tick, which has nothing to do with the switching clock, and one clock cycle is one tick. All window lengths are parameters counted in ticks.

When rail 1 leaves reset, a long first timeout starts. The first accepted rising edge of the heartbeat switches the block into windowed checking. From then on, every accepted edge opens a short closed window followed by a longer open window, and the next edge has to land in the open part. If a rule is broken, the block emits a fault pulse that keeps reset 1 low. It also latches a 2-bit code saying which rule failed. When the shutdown option is selected, it additionally requests that both switchers stop for the enable delay time.

Monitoring is suspended in three cases: reset 1 is low, the gate flag reports a regulation or global fault, or debug mode is selected. The heartbeat input passes through a level filter before it is used.

Top module: `wdg_window_monitor`

## Requirements
- R1: After reset, `fault_pulse` and `sw_off` are 0 and `fault_code` is 2'b00.
- R2: Once monitoring becomes active with the heartbeat low, an accepted rising edge must arrive within FIRST_TO ticks. An edge that is processed on the last tick is accepted. If no edge arrives, the block faults with code 2'b00.
- R3: The heartbeat changes level only after the new level has been held for FILT_TICKS consecutive ticks. A shorter glitch has no effect.
- R4: An accepted rising edge that comes CLOSED_WIN (OPEN_WIN/4) ticks or fewer after the previous one is a closed-window fault, code 2'b01.
- R5: A rising edge that comes more than CLOSED_WIN and at most OPEN_WIN ticks after the previous one restarts the window. An edge on the last tick wins over expiry. If no edge arrives in time and the input is low, the block faults with code 2'b10.
- R6: If the heartbeat stays high for a whole open window, the block faults with code 2'b11 (stuck high).
- R7: If the heartbeat is already high when monitoring becomes active, this counts as a pulse. The windows start right away instead of the first timeout.
- R8: Each fault holds `fault_pulse` high for exactly RESET_DLY+3 ticks. If monitoring is still enabled afterwards, a new first timeout starts on the next tick.
- R9: While `rst1_hi` is low, `mon_gate` is high or `debug_en` is high, no fault is raised.
- R10: With `sd_cfg` high, a fault drives `sw_off` high for EN_DLY ticks, starting in the same cycle as `fault_pulse`. With `sd_cfg` low, `sw_off` stays 0.
- R11: `fault_code` keeps its value until the next rising edge of `rst1_hi`, which clears it to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdi_raw | input | 1 | Heartbeat input from the processor |
| rst1_hi | input | 1 | Reset 1 released (high = rail 1 out of reset) |
| mon_gate | input | 1 | Regulation or global fault present; suspends monitoring |
| sd_cfg | input | 1 | Fault also requests switcher shutdown |
| debug_en | input | 1 | Debug mode; disables the watchdog |
| fault_pulse | output | 1 | Reset-extension pulse after a fault |
| fault_code | output | 2 | Latched fault type: 00 first timeout, 01 closed, 10 open, 11 stuck high |
| sw_off | output | 1 | Switcher shutdown request |

## Verification
Two functions can fall in the same tick: acceptance of a rising edge and expiry of the phase timer. Both happen when the edge is processed on the final tick of the first timeout or of the open window. The bench provokes this by spacing raw edges exactly FIRST_TO-3 ticks after release and exactly OPEN_WIN ticks apart. The edge must win, so no fault may appear. The same spacing plus one tick must give a timeout fault with the matching code. The closed-window boundary is judged the same way, at CLOSED_WIN and at CLOSED_WIN+1 ticks.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [1:0] {
      WD_IDLE = 2'd0,
      WD_TOUT = 2'd1,
      WD_WIN  = 2'd2,
      WD_HOLD = 2'd3
   } wd_state_t;

   typedef enum logic [1:0] {
      FC_FIRST  = 2'd0,
      FC_CLOSED = 2'd1,
      FC_OPEN   = 2'd2,
      FC_STUCK  = 2'd3
   } wd_fault_t;
endpackage

// File: rtl/wdg_level_filter.sv
module wdg_level_filter #(
   parameter int FILT_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic lvl,
   output logic rise
);
   generate
      if (FILT_TICKS <= 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl  <= 1'b0;
               rise <= 1'b0;
            end else begin
               rise <= raw & ~lvl;
               lvl  <= raw;
            end
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_TICKS);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl  <= 1'b0;
               rise <= 1'b0;
               cnt  <= '0;
            end else begin
               rise <= 1'b0;
               if (raw == lvl) begin
                  cnt <= '0;
               end else if (cnt == CW'(FILT_TICKS - 1)) begin
                  lvl  <= raw;
                  rise <= raw;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/wdg_phase_fsm.sv
module wdg_phase_fsm
   import wdg_pkg::*;
#(
   parameter int FIRST_TO   = 2840,
   parameter int OPEN_WIN   = 188,
   parameter int HOLD_TICKS = 53
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      active,
   input  logic      lvl,
   input  logic      rise,
   output logic      fault_evt,
   output wd_fault_t fault_kind,
   output logic      hold
);
   localparam int CLOSED_WIN = OPEN_WIN / 4;
   localparam int M1  = (FIRST_TO > OPEN_WIN) ? FIRST_TO : OPEN_WIN;
   localparam int TOP = (M1 > HOLD_TICKS) ? M1 : HOLD_TICKS;
   localparam int TW  = $clog2(TOP + 1);

   wd_state_t state, nxt_state;
   logic [TW-1:0] tmr, nxt_tmr;

   always_comb begin
      nxt_state  = state;
      nxt_tmr    = tmr + TW'(1);
      fault_evt  = 1'b0;
      fault_kind = FC_FIRST;
      unique case (state)
         WD_IDLE: begin
            nxt_tmr = '0;
            if (active) nxt_state = lvl ? WD_WIN : WD_TOUT;
         end
         WD_TOUT: begin
            if (!active) begin
               nxt_state = WD_IDLE;
               nxt_tmr   = '0;
            end else if (rise) begin
               nxt_state = WD_WIN;
               nxt_tmr   = '0;
            end else if (tmr == TW'(FIRST_TO - 1)) begin
               fault_evt  = 1'b1;
               fault_kind = FC_FIRST;
               nxt_state  = WD_HOLD;
               nxt_tmr    = '0;
            end
         end
         WD_WIN: begin
            if (!active) begin
               nxt_state = WD_IDLE;
               nxt_tmr   = '0;
            end else if (rise) begin
               nxt_tmr = '0;
               if (tmr < TW'(CLOSED_WIN)) begin
                  fault_evt  = 1'b1;
                  fault_kind = FC_CLOSED;
                  nxt_state  = WD_HOLD;
               end
            end else if (tmr == TW'(OPEN_WIN - 1)) begin
               fault_evt  = 1'b1;
               fault_kind = lvl ? FC_STUCK : FC_OPEN;
               nxt_state  = WD_HOLD;
               nxt_tmr    = '0;
            end
         end
         WD_HOLD: begin
            if (tmr == TW'(HOLD_TICKS - 1)) begin
               nxt_state = WD_IDLE;
               nxt_tmr   = '0;
            end
         end
         default: begin
            nxt_state = WD_IDLE;
            nxt_tmr   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= WD_IDLE;
         tmr   <= '0;
      end else begin
         state <= nxt_state;
         tmr   <= nxt_tmr;
      end
   end

   assign hold = (state == WD_HOLD);
endmodule

// File: rtl/wdg_stretch.sv
module wdg_stretch #(
   parameter int LEN = 160
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic out
);
   localparam int CW = $clog2(LEN + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (trig)           cnt <= CW'(LEN);
      else if (cnt != '0)      cnt <= cnt - CW'(1);
   end

   assign out = (cnt != '0);
endmodule

// File: rtl/wdg_window_monitor.sv
module wdg_window_monitor
   import wdg_pkg::*;
#(
   parameter int FIRST_TO   = 2840,
   parameter int OPEN_WIN   = 188,
   parameter int RESET_DLY  = 50,
   parameter int EN_DLY     = 160,
   parameter int FILT_TICKS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wdi_raw,
   input  logic       rst1_hi,
   input  logic       mon_gate,
   input  logic       sd_cfg,
   input  logic       debug_en,
   output logic       fault_pulse,
   output logic [1:0] fault_code,
   output logic       sw_off
);
   localparam int HOLD_TICKS = RESET_DLY + 3;

   generate
      if (OPEN_WIN < 8)            begin : g_bad_open  $error("OPEN_WIN must be at least 8 ticks");            end
      if (FIRST_TO <= OPEN_WIN)    begin : g_bad_first $error("FIRST_TO must exceed OPEN_WIN");                end
      if (FILT_TICKS < 1)          begin : g_bad_filt  $error("FILT_TICKS must be at least 1");                end
      if (RESET_DLY < 1)           begin : g_bad_rdly  $error("RESET_DLY must be at least 1");                 end
      if (EN_DLY < 1)              begin : g_bad_edly  $error("EN_DLY must be at least 1");                    end
      if (OPEN_WIN / 4 <= FILT_TICKS) begin : g_bad_cls $error("closed window must be longer than the filter"); end
   endgenerate

   logic      lvl, rise, active, fault_evt, rst1_q;
   wd_fault_t fault_kind, code_q;

   assign active = rst1_hi & ~mon_gate & ~debug_en;

   wdg_level_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(wdi_raw), .lvl(lvl), .rise(rise)
   );

   wdg_phase_fsm #(
      .FIRST_TO(FIRST_TO), .OPEN_WIN(OPEN_WIN), .HOLD_TICKS(HOLD_TICKS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .active(active), .lvl(lvl), .rise(rise),
      .fault_evt(fault_evt), .fault_kind(fault_kind), .hold(fault_pulse)
   );

   wdg_stretch #(.LEN(EN_DLY)) u_sd (
      .clk(clk), .rst_n(rst_n), .trig(fault_evt & sd_cfg), .out(sw_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst1_q <= 1'b0;
         code_q <= FC_FIRST;
      end else begin
         rst1_q <= rst1_hi;
         if (fault_evt)              code_q <= fault_kind;
         else if (rst1_hi && !rst1_q) code_q <= FC_FIRST;
      end
   end

   assign fault_code = code_q;
endmodule

// File: rtl/wdg_window_monitor_chk.sv
module wdg_window_monitor_chk #(
   parameter int RESET_DLY = 50
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rst1_hi,
   input logic       mon_gate,
   input logic       sd_cfg,
   input logic       debug_en,
   input logic       fault_pulse,
   input logic [1:0] fault_code,
   input logic       sw_off
);
   localparam int HOLD_TICKS = RESET_DLY + 3;
   localparam int RW = $clog2(HOLD_TICKS + 2);
   logic [RW-1:0] hold_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           hold_run <= '0;
      else if (fault_pulse) hold_run <= hold_run + RW'(1);
      else                  hold_run <= '0;
   end

   a_r8_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> hold_run < RW'(HOLD_TICKS));

   a_r8_hold_exact: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_pulse) |-> $past(hold_run) == RW'(HOLD_TICKS - 1));

   a_r9_only_when_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_pulse) |-> ($past(rst1_hi) && !$past(mon_gate) && !$past(debug_en)));

   a_r10_sd_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_off) |-> ($rose(fault_pulse) && $past(sd_cfg)));

   a_r11_code_latched: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fault_code) |-> ($rose(fault_pulse) || ($past(rst1_hi) && !$past(rst1_hi, 2))));
endmodule

bind wdg_window_monitor wdg_window_monitor_chk #(.RESET_DLY(RESET_DLY)) u_chk (
   .clk(clk), .rst_n(rst_n), .rst1_hi(rst1_hi), .mon_gate(mon_gate),
   .sd_cfg(sd_cfg), .debug_en(debug_en), .fault_pulse(fault_pulse),
   .fault_code(fault_code), .sw_off(sw_off)
);

// File: tb/wdg_window_monitor_tb.sv
module wdg_window_monitor_tb;
   localparam int FT = 40;
   localparam int OW = 32;
   localparam int RD = 5;
   localparam int HT = RD + 3;
   localparam int ED = 12;
   localparam int FL = 3;

   logic clk = 1'b0, rst_n = 1'b0, wdi = 1'b0, rst1 = 1'b0;
   logic gate = 1'b0, sdc = 1'b0, dbg = 1'b0;
   logic fp, swo;
   logic [1:0] code;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wdg_window_monitor #(
      .FIRST_TO(FT), .OPEN_WIN(OW), .RESET_DLY(RD), .EN_DLY(ED), .FILT_TICKS(FL)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wdi_raw(wdi), .rst1_hi(rst1), .mon_gate(gate),
      .sd_cfg(sdc), .debug_en(dbg), .fault_pulse(fp), .fault_code(code), .sw_off(swo)
   );

   task automatic tk(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic quiet(input int n, input string tag);
      int hits = 0;
      for (int i = 0; i < n; i++) begin
         tk();
         if (fp !== 1'b0) hits++;
      end
      chk(tag, hits, 0);
   endtask

   task automatic settle(input logic hi);
      rst1 = 1'b0; gate = 1'b0; dbg = 1'b0;
      while (fp) tk();
      tk(2);
      wdi = hi;
      tk(FL + 2);
   endtask

   task automatic pulse3();
      wdi = 1'b1;
      tk(3);
      wdi = 1'b0;
   endtask

   initial begin
      int c;
      tk(3);
      rst_n = 1'b1;
      tk();
      chk("R1 fault_pulse after reset", fp, 0);
      chk("R1 sw_off after reset", swo, 0);
      chk("R1 code after reset", code, 0);

      // R2 timeout with shutdown selected (R10)
      sdc = 1'b1;
      settle(1'b0); rst1 = 1'b1;
      quiet(FT, "R2 quiet before timeout");
      tk();
      chk("R2 timeout fault", fp, 1);
      chk("R2 timeout code", code, 0);
      chk("R10 sw_off with fault", swo, 1);
      c = 1; tk();
      while (swo && c < 100) begin c++; tk(); end
      chk("R10 sw_off length", c, ED);

      // R8 pulse width and restart, shutdown off
      sdc = 1'b0;
      settle(1'b0); rst1 = 1'b1;
      tk(FT + 1);
      chk("R8 fault seen", fp, 1);
      chk("R10 no sw_off when not selected", swo, 0);
      c = 1; tk();
      while (fp && c < 100) begin c++; tk(); end
      chk("R8 pulse length", c, HT);
      quiet(FT, "R8 restarted timeout quiet");
      tk();
      chk("R8 restarted timeout fault", fp, 1);

      // R2 edge on the last tick is accepted, then R5 open expiry
      settle(1'b0); rst1 = 1'b1;
      tk(FT - 3);
      pulse3();
      quiet(OW, "R2 last-tick edge accepted");
      tk();
      chk("R5 open expiry fault", fp, 1);
      chk("R5 open code", code, 2);

      // R2 edge one tick late
      settle(1'b0); rst1 = 1'b1;
      tk(FT - 2);
      pulse3();
      chk("R2 late edge faults", fp, 1);
      chk("R2 late edge code", code, 0);

      // R3 glitch ignored
      settle(1'b0); rst1 = 1'b1;
      tk(5); wdi = 1'b1; tk(2); wdi = 1'b0;
      quiet(FT - 7, "R3 glitch no effect");
      tk();
      chk("R3 glitch not a pulse", fp, 1);
      chk("R3 code first timeout", code, 0);

      // R4/R7 closed window at boundary CLOSED ticks after release
      settle(1'b1); rst1 = 1'b1; wdi = 1'b0;
      tk(5); wdi = 1'b1; tk(3);
      chk("R4 no fault before edge", fp, 0);
      tk();
      wdi = 1'b0;
      chk("R4 R7 closed fault", fp, 1);
      chk("R4 closed code", code, 1);

      // R4 boundary +1 accepted, then R6 stuck high
      settle(1'b1); rst1 = 1'b1; wdi = 1'b0;
      tk(6); wdi = 1'b1;
      quiet(35, "R4 edge after closed window accepted");
      tk();
      chk("R6 stuck fault", fp, 1);
      chk("R6 stuck code", code, 3);

      // R7 high at release starts window directly
      settle(1'b1); rst1 = 1'b1;
      quiet(OW, "R7 quiet in first window");
      tk();
      chk("R7 window from release", fp, 1);
      chk("R7 stuck code", code, 3);

      // R11 code latched, cleared by reset-1 rise
      settle(1'b0);
      chk("R11 code held while reset low", code, 3);
      gate = 1'b1; rst1 = 1'b1;
      tk();
      chk("R11 code cleared on release", code, 0);

      // R5 edge on last open tick accepted, then late edge faults
      settle(1'b0); rst1 = 1'b1;
      tk(10); pulse3();
      quiet(29, "R5 first window");
      pulse3();
      quiet(31, "R5 last-tick edge accepted");
      wdi = 1'b1;
      tk();
      chk("R5 no fault one tick before expiry", fp, 0);
      tk();
      chk("R5 expiry fault", fp, 1);
      chk("R5 expiry code", code, 2);
      wdi = 1'b0;

      // R9 debug, gate, reset low
      settle(1'b0); dbg = 1'b1; rst1 = 1'b1;
      quiet(FT + 10, "R9 debug suppresses");
      settle(1'b0); gate = 1'b1; rst1 = 1'b1;
      quiet(FT + 10, "R9 gate suppresses");
      settle(1'b0);
      quiet(FT + 10, "R9 reset low suppresses");
      chk("R9 no shutdown request", swo, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule